// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a single-port synchronous memory with a pipelined read path. Every control, address and write-data pin is sampled on the rising clock edge. Read data comes out of an output register one edge later. The external common data bus is split into a write-data input, a read-data output and a drive-enable output, so the wrapper around the block decides how the shared wires are driven.

An access opens with one of two address strobes. The processor strobe is always acted on before the controller strobe. It is also masked by the first (active-low) select. Once an access is open, the advance input steps a two-bit wrapping burst counter through four words, in either linear or interleaved order. Writes come in two forms. A controller-opened access can write in its opening cycle. A processor-opened access always starts as a read and writes on the following cycle. Writes are done per byte lane, with a write-all override.

The drive-enable output combines a registered internal enable with the asynchronous output-enable pin. It is held off in three cases: when a write is sampled, when a strobe arrives while the device is deselected, and for the first read that follows a deselected period.

Top module: `pburst_sram`

## Requirements
- R1: A read whose address is sampled on edge k presents that word on `dout`, with `drive` high, after edge k+1 (when `oe_n` is low and nothing masks it).
- R2: When both strobes are low on the same edge and the processor strobe is not masked, the access is a read of `addr` and the write inputs are ignored.
- R3: The processor strobe has no effect while `sel1_n` is high; an open burst continues instead. The controller strobe is not masked by `sel1_n`.
- R4: An access opened by the processor strobe is a read. A write with both strobes high on the next edge stores `din` at the same word, so a processor-opened write takes two cycles.
- R5: A controller-strobe access on a selected device, with a write combination and the processor strobe high, writes `din` at `addr` on that single edge. `adv_n` is ignored on that edge.
- R6: `wall_n` low writes all four lanes whatever `wbyte_n` and `bsel_n` are. Otherwise `wbyte_n` low writes lane i (bits 8i+7..8i) for each i where `bsel_n[i]` is low. An edge with no lane selected is a read.
- R7: The device is selected only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. A recognised strobe on a deselected device closes the access, writes nothing, and `drive` is low after that edge.
- R8: The first read opened after a deselected period, including the period right after reset, leaves `drive` low for its data cycle.
- R9: `drive` is low after any edge that sampled a write, even if `oe_n` is low.
- R10: With no strobe recognised and an access open, `adv_n` low steps to the next burst word and `adv_n` high repeats the current word. This holds for reads and for writes.
- R11: With `linear_mode`=1 the low two address bits of burst step n are (start+n) mod 4. With `linear_mode`=0 they are start XOR n. The upper bits do not change.
- R12: `drive` equals the registered enable ANDed with the inverse of `oe_n`, with no clock edge in between.
- R13: After reset `drive` is low, and edges without a strobe start no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| linear_mode | input | 1 | Burst order: 1 linear, 0 interleaved (static) |
| sel1_n | input | 1 | Select 1, active low; also masks the processor strobe |
| sel2 | input | 1 | Select 2, active high |
| sel3_n | input | 1 | Select 3, active low |
| pstrb_n | input | 1 | Processor address strobe, active low |
| cstrb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| addr | input | AW | Word address |
| wall_n | input | 1 | Write all lanes, active low |
| wbyte_n | input | 1 | Lane write enable, active low |
| bsel_n | input | NB | Per-lane select, active low |
| din | input | NB*8 | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | NB*8 | Registered read data |
| drive | output | 1 | High when the block should drive the data bus |

## Verification
Two pairs of functions can meet on the same edge. The first pair is a pending read output and a newly sampled write. The bench opens a processor-strobe read and then samples a write on the very next edge. It expects `drive` low for the cut read and the new word stored at the opened address. The second pair is the two strobes themselves, and the processor strobe against its select mask. The bench pulls both strobes low together with `wall_n` active and expects read data with memory unchanged. It also pulses the processor strobe with `sel1_n` high in the middle of a burst and expects the next burst word rather than the new address.

// File: rtl/pbs_pkg.sv
`timescale 1ns/1ps
package pbs_pkg;
  localparam int unsigned LANE_W = 8;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_kind_e;
endpackage

// File: rtl/pbs_access_ctl.sv
`timescale 1ns/1ps
module pbs_access_ctl
  import pbs_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned NB = 4,
  parameter int unsigned CW = 2,
  localparam int unsigned DW = NB * LANE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          linear_mode,
  input  logic          sel1_n,
  input  logic          sel2,
  input  logic          sel3_n,
  input  logic          pstrb_n,
  input  logic          cstrb_n,
  input  logic          adv_n,
  input  logic [AW-1:0] addr,
  input  logic          wall_n,
  input  logic          wbyte_n,
  input  logic [NB-1:0] bsel_n,
  input  logic [DW-1:0] din,
  output op_kind_e      op_kind_q,
  output logic          op_first_q,
  output logic [AW-1:0] op_addr_q,
  output logic [NB-1:0] op_be_q,
  output logic [DW-1:0] op_data_q,
  output logic          cut_now
);
  // decoded pins on this edge
  logic          selected;
  logic          p_hit;
  logic          strobe;
  logic [NB-1:0] be_req;
  logic          wr_req;

  // burst state
  logic [AW-1:0] base_q, base_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          active_q, active_d;
  logic [CW-1:0] off;
  logic [AW-1:0] use_addr;
  op_kind_e      kind_d;
  logic          first_d;

  always_comb begin
    selected = !sel1_n && sel2 && !sel3_n;
    p_hit    = !pstrb_n && !sel1_n;
    strobe   = p_hit || !cstrb_n;
    if (!wall_n)       be_req = '1;
    else if (!wbyte_n) be_req = ~bsel_n;
    else               be_req = '0;
    wr_req = |be_req;
  end

  always_comb begin
    base_d   = base_q;
    cnt_d    = cnt_q;
    active_d = active_q;
    kind_d   = OP_IDLE;
    first_d  = 1'b0;
    if (strobe) begin
      if (selected) begin
        base_d   = addr;
        cnt_d    = '0;
        active_d = 1'b1;
        kind_d   = (!p_hit && wr_req) ? OP_WRITE : OP_READ;
        first_d  = !active_q && (kind_d == OP_READ);
      end else begin
        active_d = 1'b0;
      end
    end else if (active_q) begin
      if (!adv_n) cnt_d = cnt_q + CW'(1);
      kind_d = wr_req ? OP_WRITE : OP_READ;
    end
  end

  always_comb begin
    if (linear_mode) off = base_d[CW-1:0] + cnt_d;
    else             off = base_d[CW-1:0] ^ cnt_d;
    use_addr = {base_d[AW-1:CW], off};
  end

  assign cut_now = (strobe && !selected) || (kind_d == OP_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q     <= '0;
      cnt_q      <= '0;
      active_q   <= 1'b0;
      op_kind_q  <= OP_IDLE;
      op_first_q <= 1'b0;
      op_addr_q  <= '0;
      op_be_q    <= '0;
      op_data_q  <= '0;
    end else begin
      base_q     <= base_d;
      cnt_q      <= cnt_d;
      active_q   <= active_d;
      op_kind_q  <= kind_d;
      op_first_q <= first_d;
      if (kind_d != OP_IDLE) op_addr_q <= use_addr;
      op_be_q    <= (kind_d == OP_WRITE) ? be_req : '0;
      op_data_q  <= din;
    end
  end

  // processor strobe on a selected device always opens a read, no lanes
  assert_proc_read_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (p_hit && selected) |=> (op_kind_q == OP_READ && op_be_q == '0));

  // controller write lands at the sampled address in one edge (R5)
  assert_ctrl_write_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (pstrb_n && !cstrb_n && selected && wr_req)
      |=> (op_kind_q == OP_WRITE && op_addr_q == $past(addr)));

  assert_deselect_idle_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !selected) |=> (op_kind_q == OP_IDLE && !active_q));

  assert_suspend_hold_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && active_q && adv_n) |=> (op_addr_q == $past(op_addr_q)));

  assert_linear_step_R11 : assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && active_q && !adv_n && linear_mode)
      |=> (op_addr_q[CW-1:0] == CW'($past(op_addr_q[CW-1:0]) + CW'(1))));
endmodule

// File: rtl/pbs_byte_array.sv
`timescale 1ns/1ps
module pbs_byte_array
  import pbs_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned NB = 4,
  localparam int unsigned DEPTH = 1 << AW,
  localparam int unsigned DW = NB * LANE_W
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [NB-1:0] be,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && be[g]) cells[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = cells[addr];
  end
endmodule

// File: rtl/pbs_out_stage.sv
`timescale 1ns/1ps
module pbs_out_stage #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_valid,
  input  logic          rd_first,
  input  logic          cut_now,
  input  logic          oe_n,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] dout,
  output logic          drive
);
  logic [DW-1:0] dout_q;
  logic          drv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      drv_q  <= 1'b0;
    end else begin
      if (rd_valid) dout_q <= rdata;
      drv_q <= rd_valid && !rd_first && !cut_now;
    end
  end

  assign dout  = dout_q;
  assign drive = drv_q && !oe_n;
endmodule

// File: rtl/pburst_sram.sv
`timescale 1ns/1ps
module pburst_sram
  import pbs_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned NB = 4,
  parameter int unsigned CW = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               linear_mode,
  input  logic               sel1_n,
  input  logic               sel2,
  input  logic               sel3_n,
  input  logic               pstrb_n,
  input  logic               cstrb_n,
  input  logic               adv_n,
  input  logic [AW-1:0]      addr,
  input  logic               wall_n,
  input  logic               wbyte_n,
  input  logic [NB-1:0]      bsel_n,
  input  logic [NB*8-1:0]    din,
  input  logic               oe_n,
  output logic [NB*8-1:0]    dout,
  output logic               drive
);
  localparam int unsigned DW = NB * LANE_W;

  op_kind_e      op_kind;
  logic          op_first;
  logic [AW-1:0] op_addr;
  logic [NB-1:0] op_be;
  logic [DW-1:0] op_data;
  logic          cut_now;
  logic [DW-1:0] rdata;

  pbs_access_ctl #(.AW(AW), .NB(NB), .CW(CW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .linear_mode(linear_mode),
    .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .pstrb_n(pstrb_n), .cstrb_n(cstrb_n), .adv_n(adv_n), .addr(addr),
    .wall_n(wall_n), .wbyte_n(wbyte_n), .bsel_n(bsel_n), .din(din),
    .op_kind_q(op_kind), .op_first_q(op_first), .op_addr_q(op_addr),
    .op_be_q(op_be), .op_data_q(op_data), .cut_now(cut_now)
  );

  pbs_byte_array #(.AW(AW), .NB(NB)) u_array (
    .clk(clk), .wr_en(op_kind == OP_WRITE), .addr(op_addr),
    .be(op_be), .wdata(op_data), .rdata(rdata)
  );

  pbs_out_stage #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .rd_valid(op_kind == OP_READ),
    .rd_first(op_first), .cut_now(cut_now), .oe_n(oe_n),
    .rdata(rdata), .dout(dout), .drive(drive)
  );

  // a write held in the op stage never coexists with bus drive (R9)
  assert_write_quiet_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    (op_kind == OP_WRITE) |-> !drive);

  // the first read after a deselected stretch never drives (R8)
  assert_first_masked_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    op_first |=> !drive);
endmodule

// File: tb/pburst_sram_bench.sv
`timescale 1ns/1ps
module pburst_sram_bench;
  localparam int AW    = 6;
  localparam int NB    = 4;
  localparam int DW    = 32;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic linear_mode = 1'b1;
  logic sel1_n = 1'b0, sel2 = 1'b1, sel3_n = 1'b0;
  logic pstrb_n = 1'b1, cstrb_n = 1'b1, adv_n = 1'b1;
  logic wall_n = 1'b1, wbyte_n = 1'b1, oe_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [NB-1:0] bsel_n = '1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          drive;

  logic [DW-1:0] ref_mem [DEPTH];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pburst_sram #(.AW(AW), .NB(NB), .CW(2)) u_pburst_sram (
    .clk(clk), .rst_n(rst_n), .linear_mode(linear_mode),
    .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .pstrb_n(pstrb_n), .cstrb_n(cstrb_n), .adv_n(adv_n), .addr(addr),
    .wall_n(wall_n), .wbyte_n(wbyte_n), .bsel_n(bsel_n), .din(din),
    .oe_n(oe_n), .dout(dout), .drive(drive)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_idle();
    sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0;
    pstrb_n = 1'b1; cstrb_n = 1'b1; adv_n = 1'b1;
    wall_n = 1'b1; wbyte_n = 1'b1; bsel_n = '1;
  endtask

  task automatic ref_write(input int a, input logic [31:0] d, input logic wall,
                           input logic wbyte, input logic [3:0] bsel);
    for (int i = 0; i < NB; i++)
      if (!wall || (!wbyte && !bsel[i])) ref_mem[a][i*8 +: 8] = d[i*8 +: 8];
  endtask

  // controller-strobe write; drive must be low right after it (R9)
  task automatic ctl_write(input int a, input logic [31:0] d, input logic wall,
                           input logic wbyte, input logic [3:0] bsel);
    pstrb_n = 1'b1; cstrb_n = 1'b0; addr = AW'(a); din = d;
    wall_n = wall; wbyte_n = wbyte; bsel_n = bsel;
    tick();
    ref_write(a, d, wall, wbyte, bsel);
    chk("R9 drive off after write edge", {31'd0, drive}, 32'd0);
    set_idle();
  endtask

  task automatic read_one(input string req, input int a);
    cstrb_n = 1'b0; addr = AW'(a);
    tick();
    set_idle();
    tick();
    chk(req, {31'd0, drive}, 32'd1);
    chk(req, dout, ref_mem[a]);
  endtask

  task automatic read_first(input string req, input int a);
    cstrb_n = 1'b0; addr = AW'(a);
    tick();
    set_idle();
    tick();
    chk("R8 first read after deselect masked", {31'd0, drive}, 32'd0);
    tick();
    chk(req, {31'd0, drive}, 32'd1);
    chk(req, dout, ref_mem[a]);
  endtask

  function automatic int baddr(input int s, input int n, input bit lin);
    int lo;
    lo = lin ? ((s + n) & 3) : ((s & 3) ^ n);
    return (s & ~3) | lo;
  endfunction

  task automatic t_reset();
    set_idle();
    rst_n = 1'b0;
    repeat (3) tick();
    chk("R13 drive low in reset", {31'd0, drive}, 32'd0);
    rst_n = 1'b1;
    adv_n = 1'b0;
    tick();
    tick();
    chk("R13 no access without strobe", {31'd0, drive}, 32'd0);
    set_idle();
  endtask

  task automatic t_fill();
    for (int i = 0; i < DEPTH; i++)
      ctl_write(i, 32'(i + 1) * 32'h9E3779B1, 1'b0, 1'b1, 4'hF);
    tick();
    tick();
    chk("R10 suspend repeats last word", {31'd0, drive}, 32'd1);
    chk("R10 suspend repeats last word", dout, ref_mem[63]);
  endtask

  task automatic t_first_read();
    cstrb_n = 1'b0; sel2 = 1'b0;
    tick();
    chk("R7 deselect cuts drive at once", {31'd0, drive}, 32'd0);
    set_idle();
    cstrb_n = 1'b0; addr = 6'd5;
    tick();
    cstrb_n = 1'b0; addr = 6'd9;
    tick();
    chk("R8 first read after deselect masked", {31'd0, drive}, 32'd0);
    set_idle();
    tick();
    chk("R1 read latency drive", {31'd0, drive}, 32'd1);
    chk("R1 read latency data", dout, ref_mem[9]);
  endtask

  task automatic t_burst(input string req, input int s, input bit lin, input bit use_p);
    linear_mode = lin; addr = AW'(s);
    if (use_p) pstrb_n = 1'b0; else cstrb_n = 1'b0;
    tick();
    pstrb_n = 1'b1; cstrb_n = 1'b1; adv_n = 1'b0;
    for (int n = 0; n < 3; n++) begin
      tick();
      chk(req, {31'd0, drive}, 32'd1);
      chk(req, dout, ref_mem[baddr(s, n, lin)]);
    end
    adv_n = 1'b1;
    tick();
    chk(req, dout, ref_mem[baddr(s, 3, lin)]);
    tick();
    chk("R10 suspend holds burst word", dout, ref_mem[baddr(s, 3, lin)]);
    set_idle();
  endtask

  task automatic t_bytes();
    ctl_write(20, 32'h11223344, 1'b1, 1'b0, 4'b1010);
    read_one("R6 lanes 0 and 2 written", 20);
    ctl_write(22, 32'hCAFEF00D, 1'b0, 1'b0, 4'b1111);
    read_one("R6 write-all overrides lane selects", 22);
    cstrb_n = 1'b0; addr = 6'd21; wbyte_n = 1'b0; bsel_n = 4'b1111; din = 32'h0;
    tick();
    set_idle();
    tick();
    chk("R6 no lane selected is a read", {31'd0, drive}, 32'd1);
    chk("R6 no lane selected is a read", dout, ref_mem[21]);
  endtask

  task automatic t_priority();
    pstrb_n = 1'b0; cstrb_n = 1'b0; addr = 6'd30; wall_n = 1'b0; din = 32'hDEADBEEF;
    tick();
    set_idle();
    tick();
    chk("R2 both strobes act as read", {31'd0, drive}, 32'd1);
    chk("R2 both strobes act as read", dout, ref_mem[30]);
    read_one("R2 memory untouched by dual strobe", 30);
  endtask

  task automatic t_proc_gate();
    linear_mode = 1'b1; cstrb_n = 1'b0; addr = 6'd40;
    tick();
    set_idle();
    pstrb_n = 1'b0; sel1_n = 1'b1; addr = 6'd50; adv_n = 1'b0;
    tick();
    chk("R3 burst data before masked strobe", dout, ref_mem[40]);
    set_idle();
    tick();
    chk("R3 masked processor strobe continues burst", {31'd0, drive}, 32'd1);
    chk("R3 masked processor strobe continues burst", dout, ref_mem[41]);
    cstrb_n = 1'b0; sel1_n = 1'b1;
    tick();
    chk("R3 controller strobe not masked (deselects)", {31'd0, drive}, 32'd0);
    set_idle();
    tick();
    chk("R7 deselected stays idle", {31'd0, drive}, 32'd0);
    read_first("R8 read after deselect then drives", 40);
  endtask

  task automatic t_desel_write();
    cstrb_n = 1'b0; sel3_n = 1'b1; addr = 6'd60; wall_n = 1'b0; din = 32'h0BADF00D;
    tick();
    chk("R7 strobe while deselected", {31'd0, drive}, 32'd0);
    set_idle();
    tick();
    read_first("R7 no write while deselected", 60);
  endtask

  task automatic t_proc_write();
    linear_mode = 1'b1; pstrb_n = 1'b0; addr = 6'd33; wall_n = 1'b0; din = 32'h55AA55AA;
    tick();
    pstrb_n = 1'b1; adv_n = 1'b1; wall_n = 1'b0; din = 32'h12345678;
    tick();
    chk("R9 write on next edge cuts pending read", {31'd0, drive}, 32'd0);
    ref_write(33, 32'h12345678, 1'b0, 1'b1, 4'hF);
    adv_n = 1'b0; din = 32'h9ABCDEF0;
    tick();
    ref_write(34, 32'h9ABCDEF0, 1'b0, 1'b1, 4'hF);
    set_idle();
    read_one("R4 two-cycle processor write", 33);
    read_one("R10 burst write advanced", 34);
  endtask

  task automatic t_ctrl_adv();
    adv_n = 1'b0;
    ctl_write(45, 32'hFEEDFACE, 1'b0, 1'b1, 4'hF);
    read_one("R5 controller write at sampled address", 45);
    read_one("R5 neighbour untouched", 46);
  endtask

  task automatic t_oe();
    cstrb_n = 1'b0; addr = 6'd10;
    tick();
    set_idle();
    oe_n = 1'b1;
    tick();
    chk("R12 oe high blocks drive", {31'd0, drive}, 32'd0);
    oe_n = 1'b0;
    #1;
    chk("R12 oe low enables drive without edge", {31'd0, drive}, 32'd1);
    chk("R12 data under oe", dout, ref_mem[10]);
  endtask

  initial begin
    t_reset();
    t_fill();
    t_first_read();
    t_burst("R11 linear from 13", 13, 1'b1, 1'b1);
    t_burst("R11 interleaved from 1", 1, 1'b0, 1'b1);
    t_burst("R11 interleaved from 27", 27, 1'b0, 1'b0);
    t_burst("R11 linear from 55", 55, 1'b1, 1'b0);
    t_bytes();
    t_priority();
    t_proc_gate();
    t_desel_write();
    t_proc_write();
    t_ctrl_adv();
    t_oe();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual still running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule